// File: doc/BRIEF.md
# Selectable Synchronous Clock Divider Bank

This block turns one input clock into three slower clocks taken from a single chain of divider stages. Every stage runs on the same internal clock, so any rising edge that two outputs have in common happens at the same instant. A ratio-set input chooses between a slow set (each output at one half, one quarter and one eighth of the input rate) and a fast set (the input rate itself, one half and one quarter).

An active-low run input passes through a flip-flop that samples on the falling edge of the input clock. That flip-flop gates the internal clock. The gate can therefore open or close only while the clock is low, and no shortened pulse can reach the divider stages. A master reset acts asynchronously and clears every stage. Several instances that share a reset therefore start out in step. The ratio set is expected to change only while the master reset is held.

Top module: `clkdiv_bank`

## Requirements
- R1: With `ratio_fast` low, `clk_out[0]`, `clk_out[1]` and `clk_out[2]` run at 1/2, 1/4 and 1/8 of the `clk_in` rate, and each changes on a rising edge of `clk_in`.
- R2: With `ratio_fast` high, `clk_out[0]` follows the gated input clock (divide by 1), and `clk_out[1]` and `clk_out[2]` run at 1/2 and 1/4 of the input rate.
- R3: Whenever the slowest divided output rises, every other divided output rises on that same input edge.
- R4: A high `run_n` that is present at a falling edge of `clk_in` stops all outputs at their current levels from the next rising edge on. In the fast set, `clk_out[0]` stays low. Driving `run_n` low again before a falling edge lets division resume from the state where it stopped.
- R5: A `run_n` pulse that begins and ends between two falling edges of `clk_in` has no effect on the outputs.
- R6: While `rst_mr` is high, all outputs are low, whatever `clk_in` and `run_n` do. Asserting `rst_mr` clears the outputs at once, with no clock edge needed.
- R7: The first rising edge of `clk_in` after `rst_mr` is released, with the gate open, drives every divided output high together. The outputs then follow the down-count sequence 7, 6, 5, …, 0 of the three stages.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Input clock |
| rst_mr | input | 1 | Master reset, active high, asynchronous |
| run_n | input | 1 | Active-low run enable, sampled on the falling edge of `clk_in` |
| ratio_fast | input | 1 | Ratio set: 0 gives /2,/4,/8 and 1 gives /1,/2,/4 |
| clk_out | output | 3 | Divided clock outputs |

## Verification
Divided outputs change in the same time step as the rising edge of `clk_in` that causes them. The bench therefore samples 1 ns after each rising edge and compares the result with the count of enabled edges since reset released. A change on `run_n` counts only from the next falling edge, so the bench drives it in the high phase and expects the following rising edge to be frozen. A pulse that stays inside one high phase leaves the next rising edge counting normally. Reset is checked 0.3 ns after it is raised, before any clock edge, so that its asynchronous effect is observed on its own.

// File: rtl/clkdiv_pkg.sv
`timescale 1ns/1ps
package clkdiv_pkg;
    localparam int unsigned TAP_COUNT = 3;

    typedef enum logic {
        RATIO_SLOW = 1'b0,
        RATIO_FAST = 1'b1
    } ratio_set_e;

    typedef struct packed {
        logic                 gate_closed;
        logic                 gclk;
    } gate_state_t;

    function automatic ratio_set_e to_ratio(input logic sel);
        return sel ? RATIO_FAST : RATIO_SLOW;
    endfunction
endpackage

// File: rtl/clkdiv_gate.sv
`timescale 1ns/1ps
module clkdiv_gate
    import clkdiv_pkg::*;
(
    input  logic        clk_in,
    input  logic        rst_mr,
    input  logic        run_n,
    output gate_state_t gate
);
    logic closed_q;

    always_ff @(negedge clk_in or posedge rst_mr) begin
        if (rst_mr) closed_q <= 1'b0;
        else        closed_q <= run_n;
    end

    assign gate.gate_closed = closed_q;
    assign gate.gclk        = clk_in & ~closed_q;
endmodule

// File: rtl/clkdiv_chain.sv
`timescale 1ns/1ps
module clkdiv_chain #(
    parameter int unsigned STAGES = 3
) (
    input  logic              gclk,
    input  logic              rst_mr,
    output logic [STAGES-1:0] stage_q
);
    logic [STAGES:0] low_all_zero;
    assign low_all_zero[0] = 1'b1;

    for (genvar j = 0; j < STAGES; j++) begin : g_stage
        assign low_all_zero[j+1] = low_all_zero[j] & ~stage_q[j];

        always_ff @(posedge gclk or posedge rst_mr) begin
            if (rst_mr)               stage_q[j] <= 1'b0;
            else if (low_all_zero[j]) stage_q[j] <= ~stage_q[j];
        end
    end
endmodule

// File: rtl/clkdiv_select.sv
`timescale 1ns/1ps
module clkdiv_select
    import clkdiv_pkg::*;
#(
    parameter int unsigned TAPS = 3
) (
    input  logic [TAPS-1:0] stage_q,
    input  logic            gclk,
    input  logic            rst_mr,
    input  logic            ratio_fast,
    output logic [TAPS-1:0] clk_out
);
    ratio_set_e set_sel;
    assign set_sel = to_ratio(ratio_fast);

    for (genvar k = 0; k < TAPS; k++) begin : g_tap
        if (k == 0) begin : g_first
            assign clk_out[k] = (set_sel == RATIO_FAST) ? (gclk & ~rst_mr) : stage_q[0];
        end else begin : g_rest
            assign clk_out[k] = (set_sel == RATIO_FAST) ? stage_q[k-1] : stage_q[k];
        end
    end
endmodule

// File: rtl/clkdiv_bank.sv
`timescale 1ns/1ps
module clkdiv_bank
    import clkdiv_pkg::*;
#(
    parameter int unsigned TAPS = TAP_COUNT
) (
    input  logic            clk_in,
    input  logic            rst_mr,
    input  logic            run_n,
    input  logic            ratio_fast,
    output logic [TAPS-1:0] clk_out
);
    gate_state_t     gate;
    logic            hold_q;
    logic [TAPS-1:0] stage_q;

    clkdiv_gate u_gate (
        .clk_in (clk_in),
        .rst_mr (rst_mr),
        .run_n  (run_n),
        .gate   (gate)
    );

    assign hold_q = gate.gate_closed;

    clkdiv_chain #(.STAGES(TAPS)) u_chain (
        .gclk    (gate.gclk),
        .rst_mr  (rst_mr),
        .stage_q (stage_q)
    );

    clkdiv_select #(.TAPS(TAPS)) u_sel (
        .stage_q    (stage_q),
        .gclk       (gate.gclk),
        .rst_mr     (rst_mr),
        .ratio_fast (ratio_fast),
        .clk_out    (clk_out)
    );
endmodule

// File: rtl/clkdiv_bank_chk.sv
`timescale 1ns/1ps
module clkdiv_bank_chk #(
    parameter int unsigned TAPS = 3
) (
    input logic            clk_in,
    input logic            rst_mr,
    input logic            hold_q,
    input logic [TAPS-1:0] stage_q,
    input logic [TAPS-1:0] clk_out
);
    AST_RESET_CLEARS: assert property (@(posedge clk_in)
        rst_mr |-> (clk_out == '0 && stage_q == '0 && !hold_q)); // R6

    AST_FIRST_STAGE_TOGGLES: assert property (@(posedge clk_in) disable iff (rst_mr)
        ($past(!hold_q) && $past(!rst_mr)) |-> (stage_q[0] != $past(stage_q[0]))); // R1

    AST_HOLD_FREEZES: assert property (@(posedge clk_in) disable iff (rst_mr)
        ($past(hold_q) && $past(!rst_mr)) |-> $stable(stage_q)); // R4

    AST_COMMON_RISE: assert property (@(posedge clk_in) disable iff (rst_mr)
        $rose(stage_q[TAPS-1]) |-> (&stage_q)); // R3
endmodule

bind clkdiv_bank clkdiv_bank_chk #(.TAPS(TAPS)) u_chk (
    .clk_in  (clk_in),
    .rst_mr  (rst_mr),
    .hold_q  (hold_q),
    .stage_q (stage_q),
    .clk_out (clk_out)
);

// File: tb/test_clkdiv_bank.sv
`timescale 1ns/1ps
module test_clkdiv_bank;
    localparam int N = 3;
    localparam int M = 1 << N;

    logic clk = 1'b0;
    logic rst_mr = 1'b1;
    logic run_n = 1'b0;
    logic ratio_fast = 1'b0;
    logic [N-1:0] clk_out;
    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    clkdiv_bank i_clkdiv_bank (
        .clk_in(clk), .rst_mr(rst_mr), .run_n(run_n),
        .ratio_fast(ratio_fast), .clk_out(clk_out)
    );

    function automatic logic [N-1:0] exp_out(int n, logic fs, logic hi);
        logic [N-1:0] s;
        s = N'((M - (n % M)) % M);
        return fs ? {s[N-2:0], hi} : s;
    endfunction

    task automatic check(string req, logic [N-1:0] act, logic [N-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic do_reset(logic fs);
        rst_mr = 1'b1; ratio_fast = fs; run_n = 1'b0;
        repeat (2) tick();
        @(negedge clk); #1;
        rst_mr = 1'b0;
    endtask

    task automatic t_reset_state();
        rst_mr = 1'b1; ratio_fast = 1'b1;
        for (int i = 0; i < 4; i++) begin
            run_n = i[0];
            tick();
            check("R6 reset state", clk_out, '0);
        end
    endtask

    task automatic t_ratios(logic fs);
        do_reset(fs);
        for (int n = 1; n <= 16; n++) begin
            tick();
            if (n == 1) check("R7 first edge all high", clk_out, exp_out(1, fs, 1'b1));
            else if (n % M == 1) check("R3 common rise", clk_out, exp_out(n, fs, 1'b1));
            else check(fs ? "R2 fast ratios" : "R1 slow ratios", clk_out, exp_out(n, fs, 1'b1));
        end
    endtask

    task automatic t_hold(logic fs);
        do_reset(fs);
        for (int n = 1; n <= 5; n++) tick();
        run_n = 1'b1;
        for (int i = 0; i < 4; i++) begin
            tick();
            check("R4 hold", clk_out, exp_out(5, fs, 1'b0));
        end
        run_n = 1'b0;
        for (int n = 6; n <= 9; n++) begin
            tick();
            check("R4 resume", clk_out, exp_out(n, fs, 1'b1));
        end
    endtask

    task automatic t_short_pulse();
        do_reset(1'b0);
        for (int n = 1; n <= 3; n++) tick();
        run_n = 1'b1; #1; run_n = 1'b0;
        for (int n = 4; n <= 6; n++) begin
            tick();
            check("R5 high-phase pulse ignored", clk_out, exp_out(n, 1'b0, 1'b1));
        end
        @(negedge clk); #0.5;
        run_n = 1'b1; #1; run_n = 1'b0;
        tick();
        check("R5 low-phase pulse ignored", clk_out, exp_out(7, 1'b0, 1'b1));
    endtask

    task automatic t_midrun_reset();
        do_reset(1'b1);
        for (int n = 1; n <= 6; n++) tick();
        rst_mr = 1'b1; #0.3;
        check("R6 async clear", clk_out, '0);
        for (int i = 0; i < 3; i++) begin
            run_n = i[0];
            tick();
            check("R6 held in reset", clk_out, '0);
        end
        run_n = 1'b0;
        @(negedge clk); #1;
        rst_mr = 1'b0;
        for (int n = 1; n <= 4; n++) begin
            tick();
            check("R7 restart sequence", clk_out, exp_out(n, 1'b1, 1'b1));
        end
    endtask

    initial begin
        t_reset_state();
        t_ratios(1'b0);
        t_ratios(1'b1);
        t_hold(1'b0);
        t_hold(1'b1);
        t_short_pulse();
        t_midrun_reset();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(5ns * 100000);
        total++; bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule